// File: doc/BRIEF.md
# Receive Ring Page Manager

This block places incoming packets into a circular receive area of packet memory. The memory is addressed as pages of 256 bytes. Three configuration inputs describe the ring: the first page of the area, the page one past its last page, and the host boundary page. The host boundary page is the first page the host has not yet released. The block never writes into it. An empty ring is shown by placing the boundary on the page just behind the current page.

A start-of-packet strobe reserves the current page. Body bytes are then stored from byte 4 of that page onward, and the write address wraps from the stop page back to the first page. When a good frame ends, the block writes a four-byte header into the reserved slot. The header links to the page where the next packet will start. The current page then moves to that page.

Three cases drop a packet and report it as missed:
- the ring is full;
- the ring is halted after an overwrite;
- monitor mode is on.

An overwrite also sets a halt flag. The host clears that flag by moving the boundary page.

Top module: `rx_ring_pager`

## Requirements
- R1: After reset the current page equals the configured first page, the halt flag is low and no memory write is issued.
- R2: Body bytes of an accepted packet are written in arrival order, starting at byte offset 4 of the current page and advancing by one address per byte.
- R3: When a byte write moves past offset 255 of the page just before the stop page, the next byte goes to offset 0 of the first page. Writes never leave the range from the first page up to, but not including, the stop page.
- R4: After a good frame ends, a header is written at offsets 0 to 3 of the reserved page. Offset 0 holds the status byte. Offset 1 holds the next-packet page. Offset 2 holds the low byte of the count and offset 3 its high byte. The count is the body length plus 4.
- R5: The next-packet page is the page after the one holding the last written byte, wrapped at the stop page. A packet with no body bytes advances by one page. The current page takes this value only in the cycle the completion pulse is high, after the header is written.
- R6: A frame that ends with the good flag low writes no header. It leaves the current page unchanged and is not reported as missed.
- R7: With monitor mode on, a packet causes no memory write, raises the missed pulse once and leaves the current page unchanged.
- R8: An overwrite is raised in two cases: a start strobe finds the current page equal to the boundary page, or a body byte would be the first write into the boundary page. An overwrite writes nothing into the boundary page, pulses the overwrite and missed outputs, drops the rest of the packet and keeps the current page.
- R9: An overwrite sets the halt flag. While the flag is high, every new packet is reported as missed and nothing is written. The flag clears in the cycle after the boundary input changes value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_start_pg | input | 8 | First page of the receive ring |
| cfg_stop_pg | input | 8 | Page one past the last ring page |
| cfg_bnd_pg | input | 8 | First page still owned by the host |
| cfg_monitor | input | 1 | Check-only mode: packets are not stored |
| rx_sop | input | 1 | Start of packet strobe |
| rx_vld | input | 1 | Body byte valid |
| rx_data | input | 8 | Body byte |
| rx_eop | input | 1 | End of frame strobe |
| rx_good | input | 1 | Frame passed its checks (valid with rx_eop) |
| rx_status | input | 8 | Status byte stored in the header (valid with rx_eop) |
| mem_we | output | 1 | Packet memory write enable |
| mem_addr | output | 16 | Packet memory byte address (page, offset) |
| mem_wdata | output | 8 | Packet memory write data |
| cur_pg | output | 8 | Page where the next packet will be stored |
| pkt_done | output | 1 | One-cycle pulse: packet stored and current page advanced |
| pkt_missed | output | 1 | One-cycle pulse: packet not stored |
| ovw_evt | output | 1 | One-cycle pulse: ring overwrite detected |
| ring_halt | output | 1 | Halt flag set by an overwrite |

## Verification
The assertions assume that the boundary page moves only while no packet is in progress. They also assume it never lands on a page the packet in progress has reserved. Framing is assumed clean: one start strobe, then bytes, then one end strobe, with no two of these in the same cycle. The bench changes the boundary and the configuration only between packets and applies a reset whenever the ring bounds change. It drives each strobe for a single cycle. Random lengths are capped so that an accepted packet fits in the free pages, and the directed cases alone push the ring into a full or halted state.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RECV,
    ST_DROP,
    ST_HDR
  } rxr_state_e;

  // bytes reserved in front of every stored packet
  localparam int HDR_BYTES = 4;
endpackage

// File: rtl/rxr_page_next.sv
// Page successor inside the ring: stop page folds back to start page.
module rxr_page_next #(
  parameter int PAGE_W = 8
) (
  input  logic [PAGE_W-1:0] pg,
  input  logic [PAGE_W-1:0] start_pg,
  input  logic [PAGE_W-1:0] stop_pg,
  output logic [PAGE_W-1:0] nxt
);
  logic [PAGE_W-1:0] inc;

  assign inc = pg + PAGE_W'(1);
  assign nxt = (inc == stop_pg) ? start_pg : inc;
endmodule

// File: rtl/rxr_hdr_mux.sv
// Selects the header byte for slot idx: status, link page, count lo, count hi.
module rxr_hdr_mux #(
  parameter int DATA_W = 8,
  parameter int PAGE_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic [1:0]        idx,
  input  logic [DATA_W-1:0] status,
  input  logic [PAGE_W-1:0] link_pg,
  input  logic [CNT_W-1:0]  body_cnt,
  output logic [DATA_W-1:0] hbyte
);
  logic [CNT_W-1:0] total;

  assign total = body_cnt + CNT_W'(rxr_pkg::HDR_BYTES);

  always_comb begin
    case (idx)
      2'd0:    hbyte = status;
      2'd1:    hbyte = DATA_W'(link_pg);
      2'd2:    hbyte = total[DATA_W-1:0];
      default: hbyte = total[2*DATA_W-1:DATA_W];
    endcase
  end
endmodule

// File: rtl/rx_ring_pager.sv
module rx_ring_pager #(
  parameter int PAGE_W = 8,
  parameter int OFF_W  = 8,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [PAGE_W-1:0]         cfg_start_pg,
  input  logic [PAGE_W-1:0]         cfg_stop_pg,
  input  logic [PAGE_W-1:0]         cfg_bnd_pg,
  input  logic                      cfg_monitor,
  input  logic                      rx_sop,
  input  logic                      rx_vld,
  input  logic [DATA_W-1:0]         rx_data,
  input  logic                      rx_eop,
  input  logic                      rx_good,
  input  logic [DATA_W-1:0]         rx_status,
  output logic                      mem_we,
  output logic [PAGE_W+OFF_W-1:0]   mem_addr,
  output logic [DATA_W-1:0]         mem_wdata,
  output logic [PAGE_W-1:0]         cur_pg,
  output logic                      pkt_done,
  output logic                      pkt_missed,
  output logic                      ovw_evt,
  output logic                      ring_halt
);
  import rxr_pkg::*;

  localparam int ADDR_W = PAGE_W + OFF_W;
  localparam logic [OFF_W-1:0] BODY_OFF = OFF_W'(HDR_BYTES);

  rxr_state_e        state;
  logic [PAGE_W-1:0] wr_pg, wr_step, end_pg, link_q, bnd_q;
  logic [OFF_W-1:0]  wr_off;
  logic [CNT_W-1:0]  body_cnt;
  logic [1:0]        hdr_idx;
  logic [DATA_W-1:0] status_q, hdr_byte;
  logic              hit_bnd;

  rxr_page_next #(.PAGE_W(PAGE_W)) u_step (
    .pg(wr_pg), .start_pg(cfg_start_pg), .stop_pg(cfg_stop_pg), .nxt(wr_step)
  );

  rxr_hdr_mux #(.DATA_W(DATA_W), .PAGE_W(PAGE_W), .CNT_W(CNT_W)) u_hdr (
    .idx(hdr_idx), .status(status_q), .link_pg(link_q),
    .body_cnt(body_cnt), .hbyte(hdr_byte)
  );

  // page holding the next packet: round the write pointer up to a page
  assign end_pg  = (wr_off == '0) ? wr_pg : wr_step;
  // first byte of a fresh page would land in host-owned space
  assign hit_bnd = (wr_off == '0) && (wr_pg == cfg_bnd_pg);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      cur_pg     <= cfg_start_pg;
      wr_pg      <= '0;
      wr_off     <= '0;
      body_cnt   <= '0;
      hdr_idx    <= '0;
      link_q     <= '0;
      status_q   <= '0;
      bnd_q      <= cfg_bnd_pg;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      pkt_done   <= 1'b0;
      pkt_missed <= 1'b0;
      ovw_evt    <= 1'b0;
      ring_halt  <= 1'b0;
    end else begin
      mem_we     <= 1'b0;
      pkt_done   <= 1'b0;
      pkt_missed <= 1'b0;
      ovw_evt    <= 1'b0;
      bnd_q      <= cfg_bnd_pg;
      if (cfg_bnd_pg != bnd_q) ring_halt <= 1'b0;

      case (state)
        ST_IDLE: begin
          if (rx_sop) begin
            if (cfg_monitor || ring_halt) begin
              pkt_missed <= 1'b1;
              state      <= ST_DROP;
            end else if (cur_pg == cfg_bnd_pg) begin
              ovw_evt    <= 1'b1;
              ring_halt  <= 1'b1;
              pkt_missed <= 1'b1;
              state      <= ST_DROP;
            end else begin
              wr_pg    <= cur_pg;
              wr_off   <= BODY_OFF;
              body_cnt <= '0;
              state    <= ST_RECV;
            end
          end
        end
        ST_RECV: begin
          if (rx_eop) begin
            if (rx_good) begin
              link_q   <= end_pg;
              status_q <= rx_status;
              hdr_idx  <= '0;
              state    <= ST_HDR;
            end else begin
              state <= ST_IDLE;
            end
          end else if (rx_vld) begin
            if (hit_bnd) begin
              ovw_evt    <= 1'b1;
              ring_halt  <= 1'b1;
              pkt_missed <= 1'b1;
              state      <= ST_DROP;
            end else begin
              mem_we    <= 1'b1;
              mem_addr  <= {wr_pg, wr_off};
              mem_wdata <= rx_data;
              wr_off    <= wr_off + OFF_W'(1);
              if (&wr_off) wr_pg <= wr_step;
              body_cnt  <= body_cnt + CNT_W'(1);
            end
          end
        end
        ST_DROP: begin
          if (rx_eop) state <= ST_IDLE;
        end
        default: begin
          mem_we    <= 1'b1;
          mem_addr  <= {cur_pg, OFF_W'(hdr_idx)};
          mem_wdata <= hdr_byte;
          hdr_idx   <= hdr_idx + 2'd1;
          if (hdr_idx == 2'd3) begin
            cur_pg   <= link_q;
            pkt_done <= 1'b1;
            state    <= ST_IDLE;
          end
        end
      endcase
    end
  end

  // ---------------- assertions ----------------
  AST_WR_INSIDE_RING: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_addr[ADDR_W-1:OFF_W] >= cfg_start_pg) &&
               (mem_addr[ADDR_W-1:OFF_W] <  cfg_stop_pg)); // R3

  AST_NO_BND_WRITE: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_addr[ADDR_W-1:OFF_W] != cfg_bnd_pg)); // R8

  AST_CUR_MOVES_ON_DONE: assert property (@(posedge clk) disable iff (rst)
    (cur_pg != $past(cur_pg)) |-> pkt_done); // R5

  AST_DONE_NOT_MISSED: assert property (@(posedge clk) disable iff (rst)
    !(pkt_done && pkt_missed)); // R6

  AST_MONITOR_NO_STORE: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && rx_sop && cfg_monitor) |=> (state == ST_DROP) && !mem_we); // R7

  AST_OVW_HALTS: assert property (@(posedge clk) disable iff (rst)
    ovw_evt |=> ring_halt || (cfg_bnd_pg != $past(cfg_bnd_pg))); // R9

  AST_HALT_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && rx_sop && ring_halt) |=> pkt_missed); // R9
endmodule

// File: tb/tb_rx_ring_pager.sv
module tb_rx_ring_pager;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] cfg_start_pg = 8'h20, cfg_stop_pg = 8'h24, cfg_bnd_pg = 8'h23;
  logic       cfg_monitor = 1'b0;
  logic       rx_sop = 1'b0, rx_vld = 1'b0, rx_eop = 1'b0, rx_good = 1'b0;
  logic [7:0] rx_data = '0, rx_status = '0;
  logic        mem_we, pkt_done, pkt_missed, ovw_evt, ring_halt;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, cur_pg;

  rx_ring_pager dut (
    .clk(clk), .rst(rst), .cfg_start_pg(cfg_start_pg), .cfg_stop_pg(cfg_stop_pg),
    .cfg_bnd_pg(cfg_bnd_pg), .cfg_monitor(cfg_monitor), .rx_sop(rx_sop),
    .rx_vld(rx_vld), .rx_data(rx_data), .rx_eop(rx_eop), .rx_good(rx_good),
    .rx_status(rx_status), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .cur_pg(cur_pg), .pkt_done(pkt_done),
    .pkt_missed(pkt_missed), .ovw_evt(ovw_evt), .ring_halt(ring_halt)
  );

  always #5 clk = ~clk;

  logic [7:0] mem [0:65535];
  logic [7:0] pkt [0:4095];
  int n_chk = 0, n_err = 0;
  int wr_cnt = 0, done_cnt = 0, miss_cnt = 0, ovw_cnt = 0, bnd_hits = 0;
  logic [7:0] exp_cur;

  always @(posedge clk) begin
    if (mem_we) begin
      mem[mem_addr] <= mem_wdata;
      wr_cnt = wr_cnt + 1;
      if (mem_addr[15:8] == cfg_bnd_pg) bnd_hits = bnd_hits + 1;
    end
    if (pkt_done)   done_cnt = done_cnt + 1;
    if (pkt_missed) miss_cnt = miss_cnt + 1;
    if (ovw_evt)    ovw_cnt  = ovw_cnt + 1;
  end

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pg_next(logic [7:0] p);
    return (p + 8'd1 == cfg_stop_pg) ? cfg_start_pg : p + 8'd1;
  endfunction

  function automatic logic [7:0] pg_prev(logic [7:0] p);
    return (p == cfg_start_pg) ? cfg_stop_pg - 8'd1 : p - 8'd1;
  endfunction

  task automatic do_reset();
    @(negedge clk) rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    exp_cur = cfg_start_pg;
    @(negedge clk);
  endtask

  task automatic send(int len, bit good, logic [7:0] st, bit gaps);
    @(negedge clk) rx_sop = 1'b1;
    @(negedge clk) rx_sop = 1'b0;
    for (int i = 0; i < len; i++) begin
      if (gaps && ($urandom % 4 == 0)) @(negedge clk);
      pkt[i]  = 8'($urandom);
      rx_vld  = 1'b1;
      rx_data = pkt[i];
      @(negedge clk) rx_vld = 1'b0;
    end
    rx_eop = 1'b1; rx_good = good; rx_status = st;
    @(negedge clk) rx_eop = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  // checks body, header and pointer update of a stored packet
  task automatic expect_good(int len, logic [7:0] st, string tag);
    logic [7:0] pg, np;
    logic [7:0] off;
    int bad, tot;
    pg = exp_cur; off = 8'd4; bad = 0; tot = len + 4;
    for (int i = 0; i < len; i++) begin
      if (mem[{pg, off}] != pkt[i]) bad++;
      off = off + 8'd1;
      if (off == 8'd0) pg = pg_next(pg);
    end
    np = (off == 8'd0) ? pg : pg_next(pg);
    check({"R2 body ", tag}, bad, 0);
    check({"R4 status ", tag}, int'(mem[{exp_cur, 8'd0}]), int'(st));
    check({"R5 link ", tag}, int'(mem[{exp_cur, 8'd1}]), int'(np));
    check({"R4 count ", tag}, int'({mem[{exp_cur, 8'd3}], mem[{exp_cur, 8'd2}]}), tot);
    check({"R5 cur ", tag}, int'(cur_pg), int'(np));
    exp_cur = np;
  endtask

  initial begin
    int w0, d0, m0, o0, h0;
    void'($urandom(32'h1234abcd));
    do_reset();
    check("R1 cur after reset", int'(cur_pg), 8'h20);
    check("R1 halt after reset", int'(ring_halt), 0);
    check("R1 no write after reset", wr_cnt, 0);

    send(60, 1'b1, 8'h01, 1'b0);
    expect_good(60, 8'h01, "short");

    cfg_bnd_pg = pg_prev(exp_cur);
    send(500, 1'b1, 8'h21, 1'b1);
    expect_good(500, 8'h21, "two pages");

    cfg_bnd_pg = pg_prev(exp_cur);
    send(300, 1'b1, 8'h41, 1'b0);      // R3 crosses stop page
    expect_good(300, 8'h41, "R3 wrap");

    cfg_bnd_pg = pg_prev(exp_cur);
    send(0, 1'b1, 8'h05, 1'b0);        // R5 empty body
    expect_good(0, 8'h05, "R5 empty");

    d0 = done_cnt; m0 = miss_cnt;
    send(80, 1'b0, 8'h02, 1'b0);
    check("R6 bad cur", int'(cur_pg), int'(exp_cur));
    check("R6 bad done", done_cnt - d0, 0);
    check("R6 bad missed", miss_cnt - m0, 0);

    w0 = wr_cnt; m0 = miss_cnt;
    cfg_monitor = 1'b1;
    send(40, 1'b1, 8'h01, 1'b0);
    cfg_monitor = 1'b0;
    check("R7 monitor writes", wr_cnt - w0, 0);
    check("R7 monitor missed", miss_cnt - m0, 1);
    check("R7 monitor cur", int'(cur_pg), int'(exp_cur));

    // R8 overwrite mid-packet: only current and next page are free
    cfg_bnd_pg = pg_next(pg_next(exp_cur));
    m0 = miss_cnt; o0 = ovw_cnt; h0 = bnd_hits; d0 = done_cnt;
    send(600, 1'b1, 8'h01, 1'b0);
    check("R8 ovw pulse", ovw_cnt - o0, 1);
    check("R8 ovw missed", miss_cnt - m0, 1);
    check("R8 no bnd write", bnd_hits - h0, 0);
    check("R8 cur kept", int'(cur_pg), int'(exp_cur));
    check("R8 no done", done_cnt - d0, 0);
    check("R9 halt set", int'(ring_halt), 1);

    w0 = wr_cnt; m0 = miss_cnt;
    send(10, 1'b1, 8'h01, 1'b0);
    check("R9 halted missed", miss_cnt - m0, 1);
    check("R9 halted writes", wr_cnt - w0, 0);
    cfg_bnd_pg = pg_prev(exp_cur);
    @(negedge clk);
    check("R9 halt cleared", int'(ring_halt), 0);
    send(10, 1'b1, 8'h11, 1'b0);
    expect_good(10, 8'h11, "R9 resume");

    // R8 full ring at start strobe
    cfg_bnd_pg = exp_cur;
    o0 = ovw_cnt; w0 = wr_cnt;
    send(20, 1'b1, 8'h01, 1'b0);
    check("R8 sop ovw", ovw_cnt - o0, 1);
    check("R8 sop writes", wr_cnt - w0, 0);
    cfg_bnd_pg = pg_prev(exp_cur);
    @(negedge clk);

    // random rings and packets
    for (int c = 0; c < 6; c++) begin
      int n, lim;
      n = 3 + int'($urandom % 6);
      cfg_start_pg = 8'($urandom % (256 - n));
      cfg_stop_pg  = cfg_start_pg + 8'(n);
      cfg_bnd_pg   = cfg_stop_pg - 8'd1;
      do_reset();
      lim = (n - 1) * 256 - 4;
      if (lim > 700) lim = 700;
      for (int k = 0; k < 8; k++) begin
        int len;
        bit good;
        logic [7:0] st;
        len  = int'($urandom % (lim + 1));
        good = ($urandom % 5) != 0;
        st   = 8'($urandom);
        cfg_bnd_pg = pg_prev(exp_cur);
        d0 = done_cnt;
        send(len, good, st, 1'b1);
        if (good) expect_good(len, st, "random");
        else check("R6 random bad", done_cnt - d0, 0);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule